// File: doc/BRIEF.md
# Four-Channel Shared-Counter PWM

This block produces four pulse-width-modulated outputs from one up-counter. Every channel has its own compare value and its own output pin. The period is common to all four channels, and each channel sets its own duty cycle. Software programs the block through a small write-only register port. Firmware writes the four compare values, then a configuration word that enables the block, selects how the period ends and pairs channels together.

There are two period modes. In the free-running mode the counter wraps when it overflows, so the period is 2^CW clock cycles. In the zero-compare mode a match on channel 0 ends the period, which gives a period of (channel 0 compare + 1) cycles. In that mode channel 0 acts only as the period source and its output stays low.

Setting a channel's pair bit limits its high window so that it ends at the next channel's match. Two such paired channels give complementary drive.

Compare values are double-buffered. Each period uses one consistent set of duty cycles.

Top module: `quad_pwm`

## Requirements
- R1: After reset, all four outputs are low and the block is disabled.
- R2: With zero-compare mode off, the counter steps by one every enabled cycle and wraps from 2^CW-1 to 0. An unpaired channel is high exactly while counter >= its compare value.
- R3: With zero-compare mode on, the counter returns to 0 on the cycle after it reaches channel 0's compare value, so the period is that value + 1 cycles. Output 0 stays low the whole time, and channels 1 to 3 follow the R2 rule within that shorter period.
- R4: With zero-compare mode on and channel 0's compare equal to 0, the counter stays at 0. Each of channels 1 to 3 then holds a constant level: high if its compare is 0, low otherwise.
- R5: A compare write is copied into the active set only at a counter reset. A write accepted on the very edge at which the counter resets takes effect one full period later.
- R6: A channel with its pair bit set is high only while (own compare) <= counter < (next channel's compare). If the next compare is not above its own, the output stays low.
- R7: The pair bit of channel 3 uses channel 0's compare value as its end point.
- R8: Register map on the write port:
  - Addresses 0 to 3 load the compare values of channels 0 to 3.
  - Address 4 loads the configuration word: bit 0 enable, bit 1 zero-compare mode, bits 5:2 pair bits for channels 0 to 3.
  - Writes to addresses 5 to 7 change nothing.
- R9: While the enable bit is clear, the counter is held at 0 and all outputs are low. When the block is enabled again, the counter restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle while high |
| wr_addr | input | 3 | Register address (see R8) |
| wr_data | input | CW | Write data; CW must be at least 6 |
| pwm_out | output | 4 | PWM outputs, bit i belongs to channel i |

The write port is a plain control interface. It has no ready signal, and it accepts a write in every cycle that wr_en is high.

## Verification
Two events can fall on the same edge: a compare write and the counter's reset. When they coincide, the reload must take the older buffered value. The bench provokes this on purpose. In zero-compare mode with a ten-cycle period, it places a channel 1 write exactly on the edge where the counter leaves 9. It then checks that the following period still uses the earlier value and that the new value appears only one period later. The same run also places a write in mid-period, which must not change the current period. Every output is compared each cycle against a duty pattern computed arithmetically from the programmed compare values.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
  localparam int QP_NCH = 4;
  localparam int QP_AW = 3;
  localparam logic [QP_AW-1:0] QP_ADDR_CFG = 3'd4;
  localparam int QP_BIT_EN = 0;
  localparam int QP_BIT_ZC = 1;
  localparam int QP_BIT_PAIR = 2;
  localparam int QP_CFG_W = QP_BIT_PAIR + QP_NCH;
endpackage

// File: rtl/qp_regs.sv
module qp_regs
  import quad_pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [QP_AW-1:0]             wr_addr,
  input  logic [CW-1:0]                wr_data,
  output logic                         en,
  output logic                         zc,
  output logic [QP_NCH-1:0]            pair,
  output logic [QP_NCH-1:0][CW-1:0]    shadow
);
  // configuration word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      zc   <= 1'b0;
      pair <= '0;
    end else if (wr_en && wr_addr == QP_ADDR_CFG) begin
      en   <= wr_data[QP_BIT_EN];
      zc   <= wr_data[QP_BIT_ZC];
      pair <= wr_data[QP_BIT_PAIR +: QP_NCH];
    end
  end

  // buffered compare values, copied to the active set at period ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < QP_NCH; i++) begin
        if (wr_addr == QP_AW'(i)) shadow[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/qp_counter.sv
module qp_counter
  import quad_pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         zc,
  input  logic [QP_NCH-1:0][CW-1:0]    shadow,
  output logic [CW-1:0]                cnt,
  output logic [QP_NCH-1:0][CW-1:0]    act,
  output logic                         pend
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  // period end: overflow, or channel 0 match in zero-compare mode.
  // ">=" keeps a compare of zero (or a mode switch mid-period) from stalling.
  always_comb begin
    pend = en && ((zc && cnt >= act[0]) || cnt == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= '0;
    end else if (!en || pend) begin
      cnt <= '0;
      act <= shadow;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/qp_channel.sv
module qp_channel #(
  parameter int CW = 16
) (
  input  logic          en,
  input  logic          blank,
  input  logic          pair,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] own,
  input  logic [CW-1:0] nxt,
  output logic          o
);
  logic hit_own;
  logic hit_nxt;
  logic window;

  always_comb begin
    hit_own = cnt >= own;
    hit_nxt = cnt >= nxt;
    window  = pair ? (hit_own && !hit_nxt) : hit_own;
    o       = en && !blank && window;
  end
endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import quad_pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [3:0]        pwm_out
);
  logic                        cfg_en;
  logic                        cfg_zc;
  logic [QP_NCH-1:0]           cfg_pair;
  logic [QP_NCH-1:0][CW-1:0]   shadow;
  logic [QP_NCH-1:0][CW-1:0]   act;
  logic [CW-1:0]               cnt;
  logic                        pend;

  qp_regs #(.CW(CW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en      (cfg_en),
    .zc      (cfg_zc),
    .pair    (cfg_pair),
    .shadow  (shadow)
  );

  qp_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg_en),
    .zc     (cfg_zc),
    .shadow (shadow),
    .cnt    (cnt),
    .act    (act),
    .pend   (pend)
  );

  for (genvar i = 0; i < QP_NCH; i++) begin : g_ch
    localparam int NXT = (i + 1) % QP_NCH;
    logic blank;
    if (i == 0) begin : g_src
      assign blank = cfg_zc;
    end else begin : g_plain
      assign blank = 1'b0;
    end
    qp_channel #(.CW(CW)) u_ch (
      .en    (cfg_en),
      .blank (blank),
      .pair  (cfg_pair[i]),
      .cnt   (cnt),
      .own   (act[i]),
      .nxt   (act[NXT]),
      .o     (pwm_out[i])
    );
  end
endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk
  import quad_pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        en,
  input logic                        zc,
  input logic [CW-1:0]               cnt,
  input logic [QP_NCH-1:0][CW-1:0]   act,
  input logic                        pend,
  input logic [3:0]                  pwm_out
);
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> pwm_out == 4'b0000);

  p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> cnt == '0);

  p_ch0_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zc |-> !pwm_out[0]);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(pend)) |-> cnt == CW'($past(cnt) + 1'b1));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend) |-> cnt == '0);

  p_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(pend)) |-> act == $past(act));

  p_zero_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && zc && act[0] == '0) |=> cnt == '0);
endmodule

bind quad_pwm quad_pwm_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (cfg_en),
  .zc      (cfg_zc),
  .cnt     (cnt),
  .act     (act),
  .pend    (pend),
  .pwm_out (pwm_out)
);

// File: tb/sim_quad_pwm.sv
`timescale 1ns/1ps
module sim_quad_pwm;
  localparam int CW = 6;
  localparam int FULL = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [3:0] pwm_out;

  always #4 clk = ~clk;

  quad_pwm #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  int n_chk = 0;
  int n_err = 0;
  int e_act[4];
  bit e_zc;
  bit [3:0] e_pair;

  function automatic logic model(int ch, int c);
    if (e_zc && ch == 0) return 1'b0;
    if (e_pair[ch]) return (c >= e_act[ch]) && (c < e_act[(ch + 1) % 4]);
    return c >= e_act[ch];
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // called at a negedge; checks n cycles, counter expected at (start+i)%per
  task automatic expect_cycles(string req, int n, int start, int per);
    for (int i = 0; i < n; i++) begin
      int c;
      c = (start + i) % per;
      for (int ch = 0; ch < 4; ch++)
        chk($sformatf("%s ch%0d cnt%0d", req, ch, c), 32'(pwm_out[ch]), 32'(model(ch, c)));
      @(negedge clk);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1;
    wr_addr = a[2:0];
    wr_data = d[CW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(bit zc, bit [3:0] pr, int a0, int a1, int a2, int a3);
    wr(4, 0);
    wr(0, a0); wr(1, a1); wr(2, a2); wr(3, a3);
    e_act[0] = a0; e_act[1] = a1; e_act[2] = a2; e_act[3] = a3;
    e_zc = zc;
    e_pair = pr;
    wr(4, 1 | (int'(zc) << 1) | (int'(pr) << 2));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 during reset", 32'(pwm_out), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after reset", 32'(pwm_out), 32'h0);

    // R2: free-running period sweep
    for (int v = 0; v < FULL; v += 3) begin
      setup(1'b0, 4'b0000, v, (v + 17) % FULL, (v * 5) % FULL, FULL - 1 - v);
      expect_cycles("R2", FULL + 4, 0, FULL);
    end

    // R3: zero-compare period sweep
    for (int a = 1; a <= 20; a++) begin
      setup(1'b1, 4'b0000, a, a / 2, a, a + 1);
      expect_cycles("R3", 2 * (a + 1) + 2, 0, a + 1);
    end

    // R4: channel 0 compare of zero in zero-compare mode
    setup(1'b1, 4'b0000, 0, 0, 3, 0);
    expect_cycles("R4", 12, 0, 1);
    setup(1'b1, 4'b0000, 0, 5, 0, 63);
    expect_cycles("R4", 12, 0, 1);

    // R6: paired windows
    setup(1'b0, 4'b0010, 0, 10, 40, 50);
    expect_cycles("R6", FULL + 4, 0, FULL);
    for (int v = 0; v < 16; v++) begin
      setup(1'b0, 4'b1111, v * 4, (v * 3 + 10) % FULL, (v * 7) % FULL, 60 - v);
      expect_cycles("R6 all paired", FULL + 4, 0, FULL);
    end

    // R7: channel 3 pair ends at channel 0 compare
    setup(1'b1, 4'b1000, 40, 5, 20, 30);
    expect_cycles("R7 zc", 2 * 41 + 2, 0, 41);
    setup(1'b0, 4'b1000, 50, 0, 0, 20);
    expect_cycles("R7 free", FULL + 4, 0, FULL);

    // R5: mid-period write and write coinciding with the counter reset
    setup(1'b1, 4'b0000, 9, 3, 6, 9);
    expect_cycles("R5 first", 4, 0, 10);
    wr(1, 7);
    expect_cycles("R5 mid-period write held", 5, 5, 10);
    e_act[1] = 7;
    expect_cycles("R5 new value", 9, 0, 10);
    wr(1, 2);
    expect_cycles("R5 write at reset edge deferred", 10, 0, 10);
    e_act[1] = 2;
    expect_cycles("R5 deferred value", 10, 0, 10);

    // R8: unused addresses have no effect
    setup(1'b0, 4'b0000, 5, 10, 15, 20);
    expect_cycles("R8", 3, 0, FULL);
    wr(5, FULL - 1);
    wr(6, 0);
    wr(7, FULL - 1);
    expect_cycles("R8 unused address", FULL + 4, 6, FULL);

    // R9: disable holds outputs low, re-enable restarts at zero
    setup(1'b0, 4'b0000, 5, 10, 15, 20);
    expect_cycles("R9 running", 30, 0, FULL);
    wr(4, 0);
    for (int i = 0; i < 6; i++) begin
      chk("R9 disabled", 32'(pwm_out), 32'h0);
      @(negedge clk);
    end
    wr(4, 1);
    expect_cycles("R9 restart", FULL + 4, 0, FULL);

    finish_run();
  end
endmodule